// File: doc/BRIEF.md
# Tournament Predictor Chooser

This block decides, branch by branch, which of two direction predictors the fetch path should believe. It keeps a table of small saturating selector counters, one per slot, with the slot picked by low bits of the branch word address. On the lookup side, it takes the branch PC and the two component guesses. It returns the guess it picked and a flag that shows which component supplied it. This path is purely combinational from the inputs and the current table contents.

When a branch resolves, the pipeline presents the branch PC and one correctness bit for each component. The counter in that slot moves only when the two components disagree in quality. If only the first component was right, the counter steps toward the first. If only the second was right, it steps toward the second. When both were right or both were wrong, the counter stays where it is. The counter has two strong states and two weak states, so a settled choice needs two contrary events in a row before it flips. The component predictors, target prediction and history tracking all sit outside this block.

Top module: `tourney_chooser`

## Requirements
- R1: After reset every selector slot holds value 1, so every lookup picks the first component (lk_use_p2 = 0) until updates change it.
- R2: The slot index is PC bits [7:2]. PCs that differ only in bits [1:0] or in bits above 7 share a slot. PCs that differ in bits [7:2] use different slots.
- R3: A selector value of 0 or 1 picks the first component (lk_use_p2 = 0). A value of 2 or 3 picks the second (lk_use_p2 = 1).
- R4: lk_dir equals lk_p2 when lk_use_p2 is 1 and lk_p1 otherwise. It follows all of its inputs in the same cycle.
- R5: An update with up_p1_ok = 1 and up_p2_ok = 0 decrements the addressed selector. The selector saturates at 0.
- R6: An update with up_p1_ok = 0 and up_p2_ok = 1 increments the addressed selector. The selector saturates at 3.
- R7: An update in which both correctness bits are equal leaves the selector unchanged.
- R8: An update takes effect at the clock edge. A lookup of the same slot in the same cycle still sees the old value, and the new value is visible from the next cycle on.
- R9: With up_valid = 0 no selector changes. An update changes only the addressed slot.
- R10: From a strong state (0 or 3), one contrary event does not change the choice, and a second consecutive contrary event does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Lookup branch PC |
| lk_p1 | input | 1 | First component's direction guess |
| lk_p2 | input | 1 | Second component's direction guess |
| lk_dir | output | 1 | Chosen direction |
| lk_use_p2 | output | 1 | 1 when the second component was chosen |
| up_valid | input | 1 | Update strobe |
| up_pc | input | 32 | PC of the resolved branch |
| up_p1_ok | input | 1 | First component predicted correctly |
| up_p2_ok | input | 1 | Second component predicted correctly |

## Verification
From the ports, the hardest state to tell apart is the strong state from the weak state on the same side, because both give the same flag. The stimulus separates them with a contrary update followed by a lookup: one contrary event flips a weak state and leaves a strong one unchanged. Tie updates are checked the same way, by showing afterwards that exactly one contrary step is still needed to flip the choice. Slot aliasing is probed by updating through one PC and looking up through PCs that differ only outside bits [7:2].

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_MIN   = '0;
  localparam sel_t SEL_MAX   = '1;
  localparam sel_t SEL_RESET = sel_t'(1);

  // next selector value for one resolved branch
  function automatic sel_t sel_step(sel_t cur, logic ok1, logic ok2);
    sel_t nxt;
    nxt = cur;
    if (ok2 && !ok1 && cur != SEL_MAX) nxt = cur + sel_t'(1);
    if (ok1 && !ok2 && cur != SEL_MIN) nxt = cur - sel_t'(1);
    return nxt;
  endfunction

  // upper half of the range trusts the second component
  function automatic logic sel_prefers_p2(sel_t cur);
    return cur[SEL_W-1];
  endfunction
endpackage

// File: rtl/tc_index.sv
module tc_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int LO = 2;
  localparam int HI = LO + IDX_W - 1;

  logic unused_bits;
  assign unused_bits = ^{pc[LO-1:0], pc[PC_W-1:HI+1]};
  assign idx = pc[HI:LO];
endmodule

// File: rtl/tc_sel_table.sv
module tc_sel_table
  import tc_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output sel_t             rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             ok1,
  input  logic             ok2
);
  logic [DEPTH-1:0][SEL_W-1:0] mem;
  sel_t wr_old;
  logic step_up, step_down, tie;

  assign rd_cnt    = mem[rd_idx];
  assign wr_old    = mem[wr_idx];
  assign tie       = wr_en && (ok1 == ok2);
  assign step_up   = wr_en && ok2 && !ok1;
  assign step_down = wr_en && ok1 && !ok2;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= SEL_RESET;
      else if (wr_en && wr_idx == IDX_W'(g))
        mem[g] <= sel_step(mem[g], ok1, ok2);
    end
  end

  // R7
  hold_on_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tie |=> mem[$past(wr_idx)] == $past(wr_old));
  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_up && wr_old != SEL_MAX |=> mem[$past(wr_idx)] > $past(wr_old));
  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_down && wr_old != SEL_MIN |=> mem[$past(wr_idx)] < $past(wr_old));
  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
  // R10
  strong_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_down && wr_old == SEL_MAX |=> sel_prefers_p2(mem[$past(wr_idx)]));
endmodule

// File: rtl/tc_pick.sv
module tc_pick
  import tc_pkg::*;
(
  input  sel_t cnt,
  input  logic p1,
  input  logic p2,
  output logic dir,
  output logic use_p2
);
  assign use_p2 = sel_prefers_p2(cnt);
  assign dir    = use_p2 ? p2 : p1;

  // R4
  always_comb begin
    if (p1 == p2) agree_pass_chk: assert (dir == p1);
  end
endmodule

// File: rtl/tourney_chooser.sv
module tourney_chooser
  import tc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_p1,
  input  logic            lk_p2,
  output logic            lk_dir,
  output logic            lk_use_p2,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_p1_ok,
  input  logic            up_p2_ok
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  sel_t lk_cnt;

  tc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (.pc(lk_pc), .idx(lk_idx));
  tc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_index (.pc(up_pc), .idx(up_idx));

  tc_sel_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_cnt(lk_cnt),
    .wr_en(up_valid), .wr_idx(up_idx),
    .ok1(up_p1_ok), .ok2(up_p2_ok)
  );

  tc_pick u_pick (
    .cnt(lk_cnt), .p1(lk_p1), .p2(lk_p2),
    .dir(lk_dir), .use_p2(lk_use_p2)
  );

  // R8: same slot looked up while written shows pre-update choice in that cycle
  same_slot_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_p2_ok && !up_p1_ok && lk_idx == up_idx && lk_cnt == SEL_RESET
      |=> $past(lk_use_p2) == 1'b0);
endmodule

// File: tb/tourney_chooser_bench.sv
module tourney_chooser_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = 0, up_pc = 0;
  logic        lk_p1 = 0, lk_p2 = 0, up_valid = 0, up_p1_ok = 0, up_p2_ok = 0;
  logic        lk_dir, lk_use_p2;

  int vectors = 0;
  int errors  = 0;
  int model [64];

  always #5 clk = ~clk;

  tourney_chooser u_tourney_chooser (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_p1(lk_p1), .lk_p2(lk_p2),
    .lk_dir(lk_dir), .lk_use_p2(lk_use_p2), .up_valid(up_valid), .up_pc(up_pc),
    .up_p1_ok(up_p1_ok), .up_p2_ok(up_p2_ok)
  );

  function automatic int slot_of(logic [31:0] pc);
    return int'((pc >> 2) & 32'h3f);
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // lookup at negedge, all four guess pairs; R3 flag, R4 direction
  task automatic look(string req, logic [31:0] pc);
    int wants2;
    wants2 = (model[slot_of(pc)] >= 2) ? 1 : 0;
    for (int k = 0; k < 4; k++) begin
      lk_pc = pc; lk_p1 = k[0]; lk_p2 = k[1];
      #1;
      check({req, "/R3 flag"}, int'(lk_use_p2), wants2);
      check({req, "/R4 dir"}, int'(lk_dir), wants2 ? k[1] : k[0]);
    end
  endtask

  task automatic upd(logic [31:0] pc, logic ok1, logic ok2);
    @(negedge clk);
    up_pc = pc; up_p1_ok = ok1; up_p2_ok = ok2; up_valid = 1;
    @(posedge clk);
    #1 up_valid = 0;
    if (ok2 && !ok1 && model[slot_of(pc)] < 3) model[slot_of(pc)]++;
    if (ok1 && !ok2 && model[slot_of(pc)] > 0) model[slot_of(pc)]--;
    @(negedge clk);
  endtask

  task automatic t_reset;
    look("R1 reset", 32'h0000_0000);
    look("R1 reset", 32'h0000_00fc);
    look("R1 reset", 32'h1234_5678);
  endtask

  task automatic t_climb;
    logic [31:0] a = 32'h0000_0010;
    upd(a, 0, 1); look("R6 weak flip", a);
    upd(a, 0, 1); look("R6 to strong", a);
    upd(a, 0, 1); look("R6 saturate", a);
    upd(a, 1, 0); look("R10 strong holds", a);
    upd(a, 1, 1); look("R7 both right", a);
    upd(a, 0, 0); look("R7 both wrong", a);
    upd(a, 1, 0); look("R10 second flips", a);
  endtask

  task automatic t_floor;
    logic [31:0] b = 32'h0000_0020;
    upd(b, 1, 0); upd(b, 1, 0); upd(b, 1, 0);
    look("R5 saturate low", b);
    upd(b, 0, 1); look("R10 low strong holds", b);
    upd(b, 0, 1); look("R5 floor was 0", b);
  endtask

  task automatic t_alias;
    logic [31:0] c = 32'h0000_0040;
    upd(c, 0, 1);
    look("R2 low bits alias", c + 32'h3);
    look("R2 high bits alias", c + 32'h0001_0100);
    look("R9 neighbour untouched", c + 32'h4);
    check("R2 alias flag", int'(lk_use_p2), 0);
  endtask

  task automatic t_idle;
    logic [31:0] d = 32'h0000_0080;
    @(negedge clk);
    up_pc = d; up_p1_ok = 0; up_p2_ok = 1; up_valid = 0;
    @(posedge clk); @(negedge clk);
    look("R9 no valid no change", d);
  endtask

  task automatic t_same_cycle;
    logic [31:0] e = 32'h0000_00c0;
    @(negedge clk);
    up_pc = e; up_p1_ok = 0; up_p2_ok = 1; up_valid = 1;
    lk_pc = e; lk_p1 = 0; lk_p2 = 1;
    #1 check("R8 old value same cycle", int'(lk_use_p2), 0);
    @(posedge clk);
    #1 up_valid = 0;
    model[slot_of(e)]++;
    @(negedge clk);
    look("R8 new value next cycle", e);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_climb;
    t_floor;
    t_alias;
    t_idle;
    t_same_cycle;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule